// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a watchdog counter for a system controller. Software reaches it through a small word-addressed register bus. The bus has three registers: a 16-bit control register, a reset-cause status register and an echo-mode register.

The control register is write-protected. A new configuration lands only in the write that directly follows an unlock key pair. A second, separate key pair restarts the running count. The configuration holds an enable bit, a reset-on-expiry bit and a 3-bit exponent code. The code picks a power-of-two timeout of 2^(BASE+n) clocks. With the default BASE of 25 and a clock near 33 MHz, codes 0 to 5 give roughly 1, 2, 4, 8, 16 and 32 seconds.

When the enabled count reaches its terminal value, several things happen:
- The block raises a one-clock system-reset request, but only if reset-on-expiry is set.
- It latches a sticky cause flag that software clears by writing one.
- It restarts the count from zero.

While the echo-mode bit is set, every write to the control address is dropped.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, the control register (address 0) reads 16'h4005: enable (bit 15) is 0, reset-on-expiry (bit 14) is 1 and the exponent code (bits 2:0) is 5. The status register (address 1) and the echo register (address 2) read 0, and sys_rst_req is low.
- R2: A write to address 0 changes the configuration only when it directly follows a write of UNLOCK_A and then a write of UNLOCK_B to address 0. Otherwise the configuration is unchanged. Only bits 15, 14 and 2:0 are stored, and all other bits read back as 0.
- R3: Once a first key has been written, any write to address 0 other than its matching second key abandons the sequence. If that write equals UNLOCK_A or REFRESH_A, it starts the matching sequence afresh.
- R4: The count restarts at zero only on a REFRESH_A write followed directly by a REFRESH_B write to address 0. A lone REFRESH_A leaves the count running.
- R5: Exponent code n from 0 to 5 sets a terminal count of 2^(BASE+n) clocks. Codes 6 and 7 behave as code 5.
- R6: While enabled, the count reaches its terminal count every 2^(BASE+n) clocks. At that point sys_rst_req is high for exactly one clock if bit 14 is set, and stays low if bit 14 is clear. The count then restarts from zero.
- R7: Status bit 0 is set on every expiry and stays set. Writing 1 to bit 0 clears it, and writing 0 has no effect. If an expiry and a clearing write fall in the same cycle, the flag stays set.
- R8: While echo register bit 0 is 1, writes to address 0 are ignored entirely: no configuration change, no key progress and no refresh. Clearing the bit restores write access.
- R9: While enable is clear, the count holds at zero and no expiry occurs.
- R10: Reads of any register never change the key-sequence state.
- R11: If the REFRESH_B write lands in the cycle in which the count would expire, the refresh wins and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Word address: 0 control, 1 status, 2 echo |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational, zero when bus_rd is low |
| sys_rst_req | output | 1 | One-clock system-reset request on expiry |

## Verification
Two pairs of events can collide in one cycle: a refresh against the expiry it is meant to prevent, and a status clear against the expiry that sets the flag. The bench uses its own reference count to place the second refresh key, and in a later pass a clearing write, exactly on the cycle in which the count sits one below its terminal value. It then judges the refresh collision by the absence of a reset pulse. It judges the clear collision by the status flag still reading 1 in the next cycle. Every cycle, the model's reset request is compared with the design's output as well.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_UNL,
    SEQ_OPEN,
    SEQ_REF
  } seq_t;

  typedef struct packed {
    logic       en;
    logic       rst_en;
    logic [2:0] exp_code;
  } wcfg_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_ECHO = 2'd2;

  localparam logic [2:0] EXP_MAX = 3'd5;

  localparam wcfg_t CFG_RESET = '{en: 1'b0, rst_en: 1'b1, exp_code: 3'd5};

  function automatic logic [2:0] clamp_exp(input logic [2:0] e);
    return (e > EXP_MAX) ? EXP_MAX : e;
  endfunction

  function automatic logic [15:0] cfg_to_word(input wcfg_t c);
    return {c.en, c.rst_en, 11'd0, c.exp_code};
  endfunction

  function automatic wcfg_t word_to_cfg(input logic [15:0] w);
    wcfg_t c;
    c.en       = w[15];
    c.rst_en   = w[14];
    c.exp_code = w[2:0];
    return c;
  endfunction

endpackage

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
  import wdt_pkg::*;
#(
  parameter logic [15:0] UNLOCK_A  = 16'h3C3C,
  parameter logic [15:0] UNLOCK_B  = 16'hC3C3,
  parameter logic [15:0] REFRESH_A = 16'hA5A5,
  parameter logic [15:0] REFRESH_B = 16'h5A5A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctrl,
  input  logic [15:0] wdata,
  output logic        cfg_load,
  output logic        refresh_hit
);

  seq_t st_q, st_d;

  function automatic seq_t first_key(input logic [15:0] v);
    if (v == UNLOCK_A)  return SEQ_UNL;
    if (v == REFRESH_A) return SEQ_REF;
    return SEQ_IDLE;
  endfunction

  always_comb begin
    st_d        = st_q;
    cfg_load    = 1'b0;
    refresh_hit = 1'b0;
    if (wr_ctrl) begin
      unique case (st_q)
        SEQ_OPEN: begin
          cfg_load = 1'b1;
          st_d     = SEQ_IDLE;
        end
        SEQ_UNL: begin
          if (wdata == UNLOCK_B) st_d = SEQ_OPEN;
          else                   st_d = first_key(wdata);
        end
        SEQ_REF: begin
          if (wdata == REFRESH_B) begin
            refresh_hit = 1'b1;
            st_d        = SEQ_IDLE;
          end else begin
            st_d = first_key(wdata);
          end
        end
        default: st_d = first_key(wdata);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= SEQ_IDLE;
    else        st_q <= st_d;
  end

  // R2: a configuration load is always preceded by the second unlock key
  p_load_after_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |-> $past(wr_ctrl && wdata == UNLOCK_B));

  // R4: a refresh is always preceded by the first refresh key
  p_refresh_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_hit |-> $past(wr_ctrl && wdata == REFRESH_A));

  // R10: without a control write the sequence state does not move
  p_quiet_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(st_q));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int BASE = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [2:0] exp_code,
  input  logic       refresh,
  output logic       expire_hit
);

  localparam int CNT_W = BASE + 6;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_val;

  function automatic logic [CNT_W-1:0] last_count(input logic [2:0] e);
    logic [CNT_W-1:0] one;
    one = {{(CNT_W-1){1'b0}}, 1'b1};
    return (one << (BASE + int'(clamp_exp(e)))) - one;
  endfunction

  assign last_val   = last_count(exp_code);
  assign expire_hit = en && !refresh && (cnt_q >= last_val);

  always_ff @(posedge clk) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (!en)                     cnt_q <= '0;
    else if (refresh || expire_hit)   cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end

  // R9: a disabled counter sits at zero
  p_hold_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt_q == '0);

  // R6: the count restarts after an expiry
  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire_hit |=> cnt_q == '0);

  // R4: a refresh restarts the count
  p_refresh_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> cnt_q == '0);

endmodule

// File: rtl/wdt_status.sv
module wdt_status (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_hit,
  input  logic rst_en,
  input  logic clr_req,
  input  logic echo_wr,
  input  logic echo_din,
  output logic sticky_q,
  output logic echo_q,
  output logic sys_rst_req
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky_q    <= 1'b0;
      echo_q      <= 1'b0;
      sys_rst_req <= 1'b0;
    end else begin
      sys_rst_req <= expire_hit && rst_en;
      if (expire_hit)   sticky_q <= 1'b1;
      else if (clr_req) sticky_q <= 1'b0;
      if (echo_wr)      echo_q <= echo_din;
    end
  end

  // R7: an expiry always leaves the flag set, even against a clear
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expire_hit |=> sticky_q);

  // R6: the reset request is a single-cycle pulse
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> !sys_rst_req);

  // R6: a reset request is always accompanied by the cause flag
  p_req_has_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> sticky_q);

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_pkg::*;
#(
  parameter int          BASE      = 25,
  parameter logic [15:0] UNLOCK_A  = 16'h3C3C,
  parameter logic [15:0] UNLOCK_B  = 16'hC3C3,
  parameter logic [15:0] REFRESH_A = 16'hA5A5,
  parameter logic [15:0] REFRESH_B = 16'h5A5A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        sys_rst_req
);

  wcfg_t cfg_q;
  logic  wr_ctrl_raw, wr_ctrl;
  logic  cfg_load, refresh_hit, expire_hit;
  logic  sticky_q, echo_q;
  logic  clr_req, echo_wr;

  assign wr_ctrl_raw = bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_ctrl     = wr_ctrl_raw && !echo_q;
  assign clr_req     = bus_wr && (bus_addr == ADDR_STAT) && bus_wdata[0];
  assign echo_wr     = bus_wr && (bus_addr == ADDR_ECHO);

  wdt_keyseq #(
    .UNLOCK_A (UNLOCK_A),
    .UNLOCK_B (UNLOCK_B),
    .REFRESH_A(REFRESH_A),
    .REFRESH_B(REFRESH_B)
  ) u_keyseq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctrl    (wr_ctrl),
    .wdata      (bus_wdata),
    .cfg_load   (cfg_load),
    .refresh_hit(refresh_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        cfg_q <= CFG_RESET;
    else if (cfg_load) cfg_q <= word_to_cfg(bus_wdata);
  end

  wdt_counter #(.BASE(BASE)) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg_q.en),
    .exp_code  (cfg_q.exp_code),
    .refresh   (refresh_hit),
    .expire_hit(expire_hit)
  );

  wdt_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .expire_hit (expire_hit),
    .rst_en     (cfg_q.rst_en),
    .clr_req    (clr_req),
    .echo_wr    (echo_wr),
    .echo_din   (bus_wdata[0]),
    .sticky_q   (sticky_q),
    .echo_q     (echo_q),
    .sys_rst_req(sys_rst_req)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        ADDR_CTRL: bus_rdata = cfg_to_word(cfg_q);
        ADDR_STAT: bus_rdata = {15'd0, sticky_q};
        ADDR_ECHO: bus_rdata = {15'd0, echo_q};
        default:   bus_rdata = '0;
      endcase
    end
  end

  // R8: with echo mode on, a control write leaves the configuration alone
  p_echo_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl_raw && echo_q) |=> $stable(cfg_q));

  // R2: the configuration moves only on an accepted load
  p_cfg_guarded_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(cfg_q));

endmodule

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;

  localparam int          BASE = 4;
  localparam logic [15:0] UA = 16'h3C3C, UB = 16'hC3C3;
  localparam logic [15:0] RA = 16'hA5A5, RB = 16'h5A5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        sys_rst_req;

  always #2.5 clk = ~clk;

  keyed_wdt #(.BASE(BASE), .UNLOCK_A(UA), .UNLOCK_B(UB),
              .REFRESH_A(RA), .REFRESH_B(RB)) u_keyed_wdt (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sys_rst_req(sys_rst_req)
  );

  int total = 0, bad = 0;
  int cyc = 0, pulses = 0, last_pulse = 0, gap = 0;

  // reference model state
  int m_en, m_ren, m_exp, m_seq, m_cnt, m_sticky, m_echo, m_req;

  function automatic int first_of(input logic [15:0] v);
    if (v == UA) return 1;
    if (v == RA) return 3;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_ren = 1; m_exp = 5; m_seq = 0; m_cnt = 0;
      m_sticky = 0; m_echo = 0; m_req = 0;
    end else begin
      int tc, e, refr, load, hit, nen, nren, nexp;
      e = (m_exp > 5) ? 5 : m_exp;
      tc = 1 << (BASE + e);
      refr = 0; load = 0;
      nen = m_en; nren = m_ren; nexp = m_exp;
      if (bus_wr && bus_addr == 2'd0 && m_echo == 0) begin
        if (m_seq == 2) begin
          load = 1; m_seq = 0;
        end else if (m_seq == 1) begin
          m_seq = (bus_wdata == UB) ? 2 : first_of(bus_wdata);
        end else if (m_seq == 3) begin
          if (bus_wdata == RB) begin refr = 1; m_seq = 0; end
          else m_seq = first_of(bus_wdata);
        end else begin
          m_seq = first_of(bus_wdata);
        end
      end
      if (load) begin
        nen = bus_wdata[15]; nren = bus_wdata[14]; nexp = int'(bus_wdata[2:0]);
      end
      hit = (m_en != 0 && !refr && m_cnt >= tc - 1) ? 1 : 0;
      m_req = (hit != 0 && m_ren != 0) ? 1 : 0;
      if (hit != 0) m_sticky = 1;
      else if (bus_wr && bus_addr == 2'd1 && bus_wdata[0]) m_sticky = 0;
      if (m_en == 0 || refr != 0 || hit != 0) m_cnt = 0;
      else m_cnt = m_cnt + 1;
      if (bus_wr && bus_addr == 2'd2) m_echo = int'(bus_wdata[0]);
      m_en = nen; m_ren = nren; m_exp = nexp;
    end
  end

  // every-cycle comparison of the reset request, plus pulse bookkeeping
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      total++;
      if (sys_rst_req !== m_req[0]) begin
        bad++;
        $display("FAIL R6 sys_rst_req got %0b exp %0b at cycle %0d",
                 sys_rst_req, m_req[0], cyc);
      end
      if (sys_rst_req === 1'b1) begin
        pulses++;
        gap = cyc - last_pulse;
        last_pulse = cyc;
      end
    end
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL R6 watchdog got cycles=%0d exp <=150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [1:0] a, input logic [15:0] e, input string tag);
    bus_rd = 1'b1; bus_addr = a;
    #1;
    total++;
    if (bus_rdata !== e) begin
      bad++;
      $display("FAIL %s read addr %0d got %h exp %h", tag, a, bus_rdata, e);
    end
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk(input bit ok, input string tag, input int got, input int e);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got %0d exp %0d", tag, got, e);
    end
  endtask

  task automatic unlock();
    wr(2'd0, UA);
    wr(2'd0, UB);
  endtask

  task automatic wait_cnt(input int v);
    while (m_cnt != v) @(negedge clk);
  endtask

  initial begin
    int p0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_exp(2'd0, 16'h4005, "R1");
    rd_exp(2'd1, 16'h0000, "R1");
    rd_exp(2'd2, 16'h0000, "R1");

    // R2 protected writes and field masking
    wr(2'd0, 16'hC000);
    rd_exp(2'd0, 16'h4005, "R2");
    unlock();
    wr(2'd0, 16'h3F03);
    rd_exp(2'd0, 16'h0003, "R2");

    // R3 aborted and restarted sequences
    wr(2'd0, UA); wr(2'd0, 16'h1234); wr(2'd0, UB); wr(2'd0, 16'h4005);
    rd_exp(2'd0, 16'h0003, "R3");
    wr(2'd0, UA); wr(2'd0, UA); wr(2'd0, UB); wr(2'd0, 16'h4001);
    rd_exp(2'd0, 16'h4001, "R3");
    wr(2'd0, RA); unlock(); wr(2'd0, 16'h4002);
    rd_exp(2'd0, 16'h4002, "R3");

    // R10 a read between keys does not break the sequence
    wr(2'd0, UA);
    rd_exp(2'd0, 16'h4002, "R10");
    wr(2'd0, UB);
    wr(2'd0, 16'h4005);
    rd_exp(2'd0, 16'h4005, "R10");

    // R8 echo mode blocks control writes
    wr(2'd2, 16'h0001);
    rd_exp(2'd2, 16'h0001, "R8");
    unlock(); wr(2'd0, 16'hC000);
    rd_exp(2'd0, 16'h4005, "R8");
    wr(2'd0, UA); wr(2'd2, 16'h0000); wr(2'd0, UB); wr(2'd0, 16'hC000);
    rd_exp(2'd0, 16'h4005, "R8");
    unlock(); wr(2'd0, 16'hC000);
    rd_exp(2'd0, 16'hC000, "R8");

    // R6 expiry with reset request, tc = 16
    p0 = pulses;
    repeat (20) @(negedge clk);
    chk(pulses == p0 + 1, "R6 pulse count", pulses, p0 + 1);
    rd_exp(2'd1, 16'h0001, "R7");
    repeat (40) @(negedge clk);
    chk(gap == 16, "R6 pulse gap", gap, 16);

    // R7 write-one-to-clear
    wait_cnt(2);
    wr(2'd1, 16'h0000);
    rd_exp(2'd1, 16'h0001, "R7");
    wr(2'd1, 16'h0001);
    rd_exp(2'd1, 16'h0000, "R7");

    // R4 regular refresh prevents expiry
    wait_cnt(1);
    p0 = pulses;
    for (int i = 0; i < 10; i++) begin
      wr(2'd0, RA); wr(2'd0, RB);
      repeat (6) @(negedge clk);
    end
    chk(pulses == p0, "R4 refreshed pulses", pulses, p0);
    wait_cnt(1);
    p0 = pulses;
    wr(2'd0, RA);
    repeat (20) @(negedge clk);
    chk(pulses == p0 + 1, "R4 lone key pulses", pulses, p0 + 1);

    // R11 refresh landing on the expiry cycle wins
    wait_cnt(14);
    p0 = pulses;
    wr(2'd0, RA); wr(2'd0, RB);
    repeat (3) @(negedge clk);
    chk(pulses == p0, "R11 collision pulses", pulses, p0);

    // R7 clear against expiry in the same cycle
    wait_cnt(3);
    wr(2'd1, 16'h0001);
    rd_exp(2'd1, 16'h0000, "R7");
    wait_cnt(15);
    wr(2'd1, 16'h0001);
    rd_exp(2'd1, 16'h0001, "R7 set-wins");

    // R5 exponent codes
    unlock(); wr(2'd0, 16'hC002);
    repeat (200) @(negedge clk);
    chk(gap == 64, "R5 code2 gap", gap, 64);
    unlock(); wr(2'd0, 16'hC007);
    repeat (1100) @(negedge clk);
    chk(gap == 512, "R5 code7 gap", gap, 512);

    // R6 expiry without reset-on-expiry
    unlock(); wr(2'd0, 16'h8000);
    wr(2'd1, 16'h0001);
    p0 = pulses;
    repeat (40) @(negedge clk);
    chk(pulses == p0, "R6 no-request pulses", pulses, p0);
    rd_exp(2'd1, 16'h0001, "R6");

    // R9 disabled counter never expires
    unlock(); wr(2'd0, 16'h4005);
    wr(2'd1, 16'h0001);
    p0 = pulses;
    repeat (1200) @(negedge clk);
    chk(pulses == p0, "R9 disabled pulses", pulses, p0);
    rd_exp(2'd1, 16'h0000, "R9");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule